// File: doc/BRIEF.md
# Bounded Delay-Tap Stepper

This block owns the tap setting of one programmable delay lane. A host places a 16-bit step count and a direction on its inputs, then pulses a single-cycle strobe. The block walks the tap value toward the requested setting one tap per clock and emits a one-cycle increment or decrement pulse to the delay element for each tap it moves. The tap register stands in for the delay element, and its value is always visible on the tap output.

The walk saturates. Upward moves stop at a fixed ceiling of 511 taps. Downward moves stop at a floor that is supplied as an input and stands for the minimum alignment setting of the delay element. A request larger than the room left is cut short at the bound and is not refused. A level `done` output is high while the block is idle. It drops for the length of a move and rises again once the move has ended. A strobe that arrives during a move is ignored.

Top module: `delay_tap_stepper`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the tap register loads `floor_tap`, `done` is 1 and both `tap_inc` and `tap_dec` are 0.
- R2: A strobe seen at a clock edge while `done` is 1 captures `step_cnt` and `step_up` (1 = increment, 0 = decrement). If the count is nonzero, `done` is 0 in the following cycle.
- R3: During a move the tap changes by exactly one per clock. In every cycle where the tap has just risen by one, `tap_inc` is 1. In every cycle where it has just fallen by one, `tap_dec` is 1. The two pulses are never high together.
- R4: The tap never exceeds 511. An increment request made at or near 511 stops at 511 and issues no further `tap_inc` pulses.
- R5: A decrement never takes the tap below `floor_tap`. A decrement request stops at the floor and issues no further `tap_dec` pulses.
- R6: A strobe with a step count of 0 leaves `done` at 1, leaves the tap unchanged and issues no pulse.
- R7: When s taps are actually moved, `done` returns to 1 exactly s+1 clock edges after the strobe edge. It then stays 1, with the tap held, until the next accepted strobe.
- R8: A strobe while `done` is 0 is ignored: the running move finishes with its own count and direction.
- R9: The full 16-bit count range is accepted. A count of 65535 in either direction ends at the matching bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| floor_tap | input | 16 | Lowest tap a decrement may reach; also the value loaded at reset |
| step_cnt | input | 16 | Number of taps requested |
| step_up | input | 1 | Direction: 1 increment, 0 decrement |
| adj_strobe | input | 1 | Starts a move when `done` is 1 |
| done | output | 1 | High while idle, low while a move is running |
| tap_val | output | 16 | Current tap value |
| tap_inc | output | 1 | One-cycle pulse per tap moved upward |
| tap_dec | output | 1 | One-cycle pulse per tap moved downward |

## Verification
Every result arrives on a fixed cycle relative to the strobe edge. `done` falls one edge after the strobe. The k-th tap change and its pulse appear after edge k. `done` rises after edge s+1, where s is the number of taps the bounds allow. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the strobe edge until `done` returns and compares that count with s+1. It tallies the pulses seen in each cycle, and it checks the idle and reset values in the cycle right after the edge that should produce them.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int TAP_W = 16;
  typedef logic [TAP_W-1:0] tap_t;

  // room left in the requested direction
  function automatic logic tap_hits_top(input tap_t tap, input tap_t ceil);
    return tap >= ceil;
  endfunction

  function automatic logic tap_hits_floor(input tap_t tap, input tap_t flr);
    return tap <= flr;
  endfunction

  function automatic tap_t tap_next(input tap_t tap, input logic up);
    return up ? tap + tap_t'(1) : tap - tap_t'(1);
  endfunction
endpackage

// File: rtl/tap_seq.sv
module tap_seq
  import tap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adj_strobe,
  input  tap_t step_cnt,
  input  logic step_up,
  input  logic at_top,
  input  logic at_floor,
  output logic busy,
  output logic dir_up,
  output logic step_fire
);
  tap_t remain_q;
  logic busy_q, dir_q;
  logic accept, blocked;

  assign accept    = !busy_q && adj_strobe && (step_cnt != '0);
  assign blocked   = dir_q ? at_top : at_floor;
  assign step_fire = busy_q && (remain_q != '0) && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_q    <= 1'b0;
      remain_q <= '0;
    end else if (!busy_q) begin
      if (accept) begin
        busy_q   <= 1'b1;
        dir_q    <= step_up;
        remain_q <= step_cnt;
      end
    end else if (step_fire) begin
      remain_q <= remain_q - tap_t'(1);
    end else begin
      busy_q <= 1'b0;
    end
  end

  assign busy   = busy_q;
  assign dir_up = dir_q;

  // R8
  strobe_while_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && adj_strobe) |=> $stable(dir_q));
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !adj_strobe) |=> !busy_q);
endmodule

// File: rtl/tap_reg.sv
module tap_reg
  import tap_pkg::*;
#(
  parameter int TAP_MAX = 511
) (
  input  logic clk,
  input  logic rst_n,
  input  tap_t floor_tap,
  input  logic step_fire,
  input  logic dir_up,
  output tap_t tap_val,
  output logic at_top,
  output logic at_floor,
  output logic tap_inc,
  output logic tap_dec
);
  localparam tap_t CEIL = tap_t'(TAP_MAX);

  tap_t tap_q;
  logic inc_q, dec_q;

  assign at_top   = tap_hits_top(tap_q, CEIL);
  assign at_floor = tap_hits_floor(tap_q, floor_tap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q <= floor_tap;
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      inc_q <= step_fire && dir_up;
      dec_q <= step_fire && !dir_up;
      if (step_fire) tap_q <= tap_next(tap_q, dir_up);
    end
  end

  assign tap_val = tap_q;
  assign tap_inc = inc_q;
  assign tap_dec = dec_q;

  // R3
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_q, dec_q}));
  // R3
  inc_moves_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_q |-> (tap_q == $past(tap_q) + tap_t'(1)));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_q <= CEIL);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_q |-> ($past(tap_q) > $past(floor_tap)));
endmodule

// File: rtl/delay_tap_stepper.sv
module delay_tap_stepper
  import tap_pkg::*;
#(
  parameter int TAP_MAX = 511
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] floor_tap,
  input  logic [15:0] step_cnt,
  input  logic        step_up,
  input  logic        adj_strobe,
  output logic        done,
  output logic [15:0] tap_val,
  output logic        tap_inc,
  output logic        tap_dec
);
  logic busy, dir_up, step_fire, at_top, at_floor;

  tap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .adj_strobe(adj_strobe),
    .step_cnt(step_cnt), .step_up(step_up),
    .at_top(at_top), .at_floor(at_floor),
    .busy(busy), .dir_up(dir_up), .step_fire(step_fire)
  );

  tap_reg #(.TAP_MAX(TAP_MAX)) u_reg (
    .clk(clk), .rst_n(rst_n), .floor_tap(floor_tap),
    .step_fire(step_fire), .dir_up(dir_up),
    .tap_val(tap_val), .at_top(at_top), .at_floor(at_floor),
    .tap_inc(tap_inc), .tap_dec(tap_dec)
  );

  assign done = !busy;

  // R7
  done_tap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !adj_strobe) |=> $stable(tap_val));
  // R6
  zero_count_stays_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && adj_strobe && step_cnt == 16'd0) |=> done);
endmodule

// File: tb/delay_tap_stepper_bench.sv
module delay_tap_stepper_bench;
  localparam int FLOOR = 20;
  localparam int NV = 10;
  // {count[15:0], up, expected tap[15:0], expected taps moved[15:0]}
  localparam logic [48:0] VEC [NV] = '{
    {16'd5,     1'b1, 16'd25,  16'd5},
    {16'd3,     1'b0, 16'd22,  16'd3},
    {16'd10,    1'b0, 16'd20,  16'd2},
    {16'd0,     1'b1, 16'd20,  16'd0},
    {16'd600,   1'b1, 16'd511, 16'd491},
    {16'd2,     1'b1, 16'd511, 16'd0},
    {16'd11,    1'b0, 16'd500, 16'd11},
    {16'd65535, 1'b1, 16'd511, 16'd11},
    {16'd65535, 1'b0, 16'd20,  16'd491},
    {16'd1,     1'b1, 16'd21,  16'd1}
  };

  logic clk = 0, rst_n = 0, step_up = 0, adj_strobe = 0;
  logic [15:0] floor_tap = 16'(FLOOR), step_cnt = 0;
  logic done, tap_inc, tap_dec;
  logic [15:0] tap_val;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  delay_tap_stepper u_delay_tap_stepper (
    .clk(clk), .rst_n(rst_n), .floor_tap(floor_tap), .step_cnt(step_cnt),
    .step_up(step_up), .adj_strobe(adj_strobe), .done(done),
    .tap_val(tap_val), .tap_inc(tap_inc), .tap_dec(tap_dec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe for one cycle, then follow the move until done; report counts
  task automatic run_move(input int cnt, input bit up,
                          output int edges, output int incs, output int decs, output int both);
    @(negedge clk);
    step_cnt = 16'(cnt); step_up = up; adj_strobe = 1;
    @(negedge clk);
    adj_strobe = 0;
    edges = 0; incs = 0; decs = 0; both = 0;
    check(done == (cnt == 0), "R2 done after strobe", done, cnt == 0);
    while (!done && edges < 70000) begin
      @(negedge clk);
      edges++;
      if (tap_inc) incs++;
      if (tap_dec) decs++;
      if (tap_inc && tap_dec) both++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int edges, incs, decs, both, start;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tap_val == 16'(FLOOR), "R1 reset tap", tap_val, FLOOR);
    check(done == 1, "R1 reset done", done, 1);
    check(!tap_inc && !tap_dec, "R1 reset pulses", {tap_inc, tap_dec}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int cnt, exp_tap, exp_s; bit up;
      cnt = int'(VEC[i][48:33]); up = VEC[i][32];
      exp_tap = int'(VEC[i][31:16]); exp_s = int'(VEC[i][15:0]);
      start = tap_val;
      run_move(cnt, up, edges, incs, decs, both);
      // R4 R5 R9 final tap with clamping
      check(tap_val == 16'(exp_tap), "R4/R5/R9 final tap", tap_val, exp_tap);
      // R3 pulse count and direction
      check((up ? incs : decs) == exp_s, "R3 pulse count", up ? incs : decs, exp_s);
      check((up ? decs : incs) == 0 && both == 0, "R3 wrong pulse", up ? decs : incs, 0);
      if (cnt == 0)
        check(edges == 0 && tap_val == 16'(start), "R6 zero count", edges, 0);
      else
        check(edges == exp_s + 1, "R7 done latency", edges, exp_s + 1);
    end

    // R7 done holds and tap stays when idle
    start = tap_val;
    repeat (5) @(negedge clk);
    check(done == 1 && tap_val == 16'(start), "R7 idle hold", tap_val, start);

    // R8 strobe while busy is ignored
    @(negedge clk);
    start = tap_val;
    step_cnt = 16'd10; step_up = 1; adj_strobe = 1;
    @(negedge clk);
    adj_strobe = 0;
    repeat (2) @(negedge clk);
    step_cnt = 16'd50; step_up = 0; adj_strobe = 1;
    @(negedge clk);
    adj_strobe = 0;
    edges = 0;
    while (!done && edges < 100) begin @(negedge clk); edges++; end
    check(tap_val == 16'(start + 10), "R8 busy strobe ignored", tap_val, start + 10);

    // R1 reset during a move returns to floor
    step_cnt = 16'd40; step_up = 1; adj_strobe = 1;
    @(negedge clk);
    adj_strobe = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(tap_val == 16'(FLOOR) && done == 1, "R1 reset mid-move", tap_val, FLOOR);
    rst_n = 1;
    @(negedge clk);

    // R5 raised floor blocks decrement
    floor_tap = 16'd30;
    run_move(5, 1'b0, edges, incs, decs, both);
    check(decs == 0 && tap_val == 16'(FLOOR), "R5 below raised floor", decs, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule